// File: doc/BRIEF.md
# Prefetch Candidate Queue Manager

This block keeps the hardware prefetch requests that are waiting to go out between an address generator and the memory-side request port. When the cache reports an access, the block takes the demand address and up to `NC` generated candidates, each with its own delay. It removes any waiting entry that the demand access now covers. It can also discard entries that are not ready yet. It then filters the candidates against the cache tags, the miss-status queue and its own contents, and appends the candidates that survive, each with a ready time. A full queue drops its oldest entry to make room for a new one.

All matching works on block addresses, with the byte offset inside a block cleared. The block shows the head entry and its ready time continuously, so the bus side can decide when to ask for the bus. A pop hands the head entry out. The tag and miss-status lookups are done outside the block and arrive as per-candidate hit bits. Six saturating event counters record what happened to the entries.

Top module: `pfq_manager`

## Requirements
- R1: After reset the queue is empty, `head_valid` is 0, `head_ready` is all ones, `rsp_valid` and `pop_valid` are 0, and every event counter reads 0.
- R2: Every address is reduced to its block address by clearing the low log2(`BLK_BYTES`) bits before it is stored or compared, so a demand address anywhere inside a queued block matches that block.
- R3: On a processed notification, a queued entry whose block equals the demand block is removed, and `cnt_rm_miss` goes up by one.
- R4: With `cfg_serial_squash` = 1, after the demand match, entries are discarded one at a time starting from the tail, for as long as each one's ready time is greater than or equal to `ntf_time`. The discarding stops at the first entry that is older than that. Each discarded entry adds one to `cnt_squashed`. With the mode off, no entry is squashed.
- R5: Valid candidates are handled in index order 0 to NC-1. A candidate is dropped if it hits in the cache while `cfg_chk_on_push` = 1, or if it hits in the miss-status queue. Otherwise it is dropped if its block is already queued, including a block appended earlier in the same notification, and `cnt_dup` goes up by one. As a result, no block is ever queued twice.
- R6: When a surviving candidate finds the queue holding `DEPTH` entries, the head entry is discarded first and `cnt_rm_full` goes up by one. The occupancy never exceeds `DEPTH`.
- R7: A candidate that survives is appended at the tail, with ready time `ntf_time` + its delay, taken modulo 2^`TW`.
- R8: One cycle after each processed notification, `rsp_valid` is 1 for one cycle. `rsp_time` then holds the head entry's ready time after processing, or 0 if the queue is empty.
- R9: `head_ready` holds the head entry's ready time, or all ones when the queue is empty. `head_addr` holds the head entry's block.
- R10: A `pop_req` to a non-empty queue removes the head entry. If `cfg_chk_on_push` = 0 and `pop_head_in_cache` = 1, the head is discarded and nothing is returned. Otherwise, in the next cycle, `pop_valid` is 1, `pop_addr` carries the head block, and `cnt_issued` goes up by one. A pop to an empty queue returns nothing.
- R11: A notification with `ntf_uncached` = 1, or with `ntf_ifetch` = 1 while `cfg_data_only` = 1, changes nothing: the queue is unchanged, no response is produced and no counter moves.
- R12: `cnt_identified` goes up by the number of valid candidates in each processed notification. Every counter stops at 2^`CW`-1.
- R13: When a pop and a notification happen in the same cycle, the pop acts first and the notification then works on the queue left after the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chk_on_push | input | 1 | 1: check the cache when a candidate is pushed; 0: check the cache at pop time |
| cfg_serial_squash | input | 1 | Turns on squashing of entries that are not yet ready |
| cfg_data_only | input | 1 | Ignore instruction-fetch notifications |
| ntf_valid | input | 1 | An access notification is present |
| ntf_addr | input | AW | Demand access byte address |
| ntf_time | input | TW | Current time for the notification |
| ntf_uncached | input | 1 | The access is uncacheable |
| ntf_ifetch | input | 1 | The access is an instruction fetch |
| cand_valid | input | NC | Per-candidate valid bits |
| cand_addr | input | NC*AW | Candidate byte addresses |
| cand_delay | input | NC*DW | Per-candidate delay added to `ntf_time` |
| cand_in_cache | input | NC | Tag lookup hit for each candidate |
| cand_in_mshr | input | NC | Miss-status lookup hit for each candidate |
| pop_req | input | 1 | Take the head entry |
| pop_head_in_cache | input | 1 | Tag lookup hit for the current `head_addr` |
| head_valid | output | 1 | The queue is non-empty |
| head_addr | output | AW | Head entry block address |
| head_ready | output | TW | Head ready time, all ones when empty |
| rsp_valid | output | 1 | Notification result is valid |
| rsp_time | output | TW | Head ready time after the notification, 0 if empty |
| pop_valid | output | 1 | A popped entry is returned |
| pop_addr | output | AW | Popped block address |
| cnt_identified | output | CW | Valid candidates seen |
| cnt_issued | output | CW | Entries handed out by pops |
| cnt_rm_miss | output | CW | Entries removed by a demand match |
| cnt_rm_full | output | CW | Entries evicted from a full queue |
| cnt_squashed | output | CW | Entries removed by serial squash |
| cnt_dup | output | CW | Candidates already present in the queue |

## Verification
The bench builds the block with `DEPTH` = 4, `NC` = 3, 16-byte blocks, 16-bit addresses and times, and 4-bit counters. Candidates and demand addresses are drawn from only eight blocks, with random low offset bits. With these values, demand matches, duplicates inside a single notification, full-queue eviction with several evictions in one cycle, and counter saturation at 15 all occur within a few hundred cycles. A time base that steps by one, combined with delays of 0 to 15, leaves both squashable and older entries in the queue, so serial squash both discards entries and stops partway. The configuration bits are drawn again every 200 cycles, so the cache check is exercised both at push time and at pop time.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum int {
        EV_IDENT   = 0,
        EV_ISSUED  = 1,
        EV_RM_MISS = 2,
        EV_RM_FULL = 3,
        EV_SQUASH  = 4,
        EV_DUP     = 5
    } pfq_event_e;

    localparam int PFQ_NUM_EV = 6;

    typedef struct packed {
        logic chk_on_push;
        logic serial_squash;
        logic data_only;
    } pfq_cfg_t;

endpackage

// File: rtl/pfq_cand_filter.sv
module pfq_cand_filter #(
    parameter int AW        = 32,
    parameter int NC        = 4,
    parameter int BLK_BYTES = 64
) (
    input  logic                   chk_on_push,
    input  logic [NC-1:0]          cand_valid,
    input  logic [NC-1:0][AW-1:0]  cand_addr,
    input  logic [NC-1:0]          cand_in_cache,
    input  logic [NC-1:0]          cand_in_mshr,
    output logic [NC-1:0][AW-1:0]  cand_blk,
    output logic [NC-1:0]          cand_pass
);
    localparam logic [AW-1:0] BLK_MASK = ~AW'(BLK_BYTES - 1);

    for (genvar c = 0; c < NC; c++) begin : g_cand
        assign cand_blk[c]  = cand_addr[c] & BLK_MASK;
        assign cand_pass[c] = cand_valid[c]
                            && !(chk_on_push && cand_in_cache[c])
                            && !cand_in_mshr[c];
    end

endmodule

// File: rtl/pfq_event_ctr.sv
module pfq_event_ctr #(
    parameter int CW = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] inc,
    output logic [CW-1:0] count
);
    localparam int            SW      = CW + IW + 1;
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] count_d, count_q;
    logic [SW-1:0] sum;

    always_comb begin
        sum     = SW'(count_q) + SW'(inc);
        count_d = (sum > SW'(CNT_MAX)) ? CNT_MAX : sum[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

    AST_CTR_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count_q >= $past(count_q)); // R12

endmodule

// File: rtl/pfq_store.sv
module pfq_store #(
    parameter int AW        = 32,
    parameter int TW        = 32,
    parameter int DW        = 8,
    parameter int DEPTH     = 100,
    parameter int NC        = 4,
    parameter int CNTW      = 7,
    parameter int IW        = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   chk_on_push,
    input  logic                   serial_squash,
    input  logic                   ntf_act,
    input  logic [AW-1:0]          ntf_blk,
    input  logic [TW-1:0]          ntf_time,
    input  logic [NC-1:0]          cand_pass,
    input  logic [NC-1:0][AW-1:0]  cand_blk,
    input  logic [NC-1:0][DW-1:0]  cand_delay,
    input  logic                   pop_req,
    input  logic                   pop_head_in_cache,
    output logic                   head_valid,
    output logic [AW-1:0]          head_addr,
    output logic [TW-1:0]          head_ready,
    output logic                   rsp_valid,
    output logic [TW-1:0]          rsp_time,
    output logic                   pop_valid,
    output logic [AW-1:0]          pop_addr,
    output logic [CNTW-1:0]        occupancy,
    output logic [IW-1:0]          inc_issued,
    output logic [IW-1:0]          inc_rm_miss,
    output logic [IW-1:0]          inc_rm_full,
    output logic [IW-1:0]          inc_squash,
    output logic [IW-1:0]          inc_dup
);
    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][TW-1:0] rdy;
        logic [CNTW-1:0]          occ;
        logic                     rsp_v;
        logic [TW-1:0]            rsp_t;
        logic                     pop_v;
        logic [AW-1:0]            pop_a;
    } store_st_t;

    store_st_t      s_d, s_q;
    logic           hit_found;
    logic [CNTW-1:0] hit_idx;
    logic           sq_stop;
    logic           is_dup;

    always_comb begin
        s_d         = s_q;
        s_d.rsp_v   = 1'b0;
        s_d.pop_v   = 1'b0;
        inc_issued  = '0;
        inc_rm_miss = '0;
        inc_rm_full = '0;
        inc_squash  = '0;
        inc_dup     = '0;
        hit_found   = 1'b0;
        hit_idx     = '0;
        sq_stop     = 1'b0;
        is_dup      = 1'b0;

        // pop acts before any notification in the same cycle
        if (pop_req && s_d.occ != '0) begin
            if (!(~chk_on_push && pop_head_in_cache)) begin
                s_d.pop_v  = 1'b1;
                s_d.pop_a  = s_d.addr[0];
                inc_issued = IW'(1);
            end
            for (int j = 0; j < DEPTH - 1; j++) begin
                s_d.addr[j] = s_d.addr[j+1];
                s_d.rdy[j]  = s_d.rdy[j+1];
            end
            s_d.occ = s_d.occ - CNTW'(1);
        end

        if (ntf_act) begin
            // demand match cancels the queued copy of that block
            for (int i = 0; i < DEPTH; i++) begin
                if (!hit_found && CNTW'(i) < s_d.occ && s_d.addr[i] == ntf_blk) begin
                    hit_found = 1'b1;
                    hit_idx   = CNTW'(i);
                end
            end
            if (hit_found) begin
                for (int j = 0; j < DEPTH - 1; j++) begin
                    if (CNTW'(j) >= hit_idx) begin
                        s_d.addr[j] = s_d.addr[j+1];
                        s_d.rdy[j]  = s_d.rdy[j+1];
                    end
                end
                s_d.occ     = s_d.occ - CNTW'(1);
                inc_rm_miss = IW'(1);
            end

            // serial squash walks from the tail toward the head
            if (serial_squash) begin
                for (int k = DEPTH - 1; k >= 0; k--) begin
                    if (!sq_stop && CNTW'(k) < s_d.occ) begin
                        if (s_d.rdy[k] >= ntf_time) begin
                            s_d.occ    = CNTW'(k);
                            inc_squash = inc_squash + IW'(1);
                        end else begin
                            sq_stop = 1'b1;
                        end
                    end
                end
            end

            // candidates in index order
            for (int c = 0; c < NC; c++) begin
                if (cand_pass[c]) begin
                    is_dup = 1'b0;
                    for (int i = 0; i < DEPTH; i++) begin
                        if (CNTW'(i) < s_d.occ && s_d.addr[i] == cand_blk[c]) begin
                            is_dup = 1'b1;
                        end
                    end
                    if (is_dup) begin
                        inc_dup = inc_dup + IW'(1);
                    end else begin
                        if (s_d.occ == CNTW'(DEPTH)) begin
                            for (int j = 0; j < DEPTH - 1; j++) begin
                                s_d.addr[j] = s_d.addr[j+1];
                                s_d.rdy[j]  = s_d.rdy[j+1];
                            end
                            s_d.occ     = s_d.occ - CNTW'(1);
                            inc_rm_full = inc_rm_full + IW'(1);
                        end
                        for (int i = 0; i < DEPTH; i++) begin
                            if (CNTW'(i) == s_d.occ) begin
                                s_d.addr[i] = cand_blk[c];
                                s_d.rdy[i]  = ntf_time + TW'(cand_delay[c]);
                            end
                        end
                        s_d.occ = s_d.occ + CNTW'(1);
                    end
                end
            end

            s_d.rsp_v = 1'b1;
            s_d.rsp_t = (s_d.occ != '0) ? s_d.rdy[0] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_valid = (s_q.occ != '0);
    assign head_addr  = s_q.addr[0];
    assign head_ready = (s_q.occ != '0) ? s_q.rdy[0] : '1;
    assign rsp_valid  = s_q.rsp_v;
    assign rsp_time   = s_q.rsp_t;
    assign pop_valid  = s_q.pop_v;
    assign pop_addr   = s_q.pop_a;
    assign occupancy  = s_q.occ;

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.occ <= CNTW'(DEPTH)); // R6

    AST_POP_EMPTY_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && s_q.occ == '0) |=> !pop_valid); // R10

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && s_q.occ != '0 && !ntf_act) |=> s_q.occ == $past(s_q.occ) - CNTW'(1)); // R10

    AST_GROWTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_act && !pop_req) |=> ({1'b0, s_q.occ} <= {1'b0, $past(s_q.occ)} + (CNTW+1)'(NC))); // R7

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ntf_act) |=> !rsp_valid); // R8

endmodule

// File: rtl/pfq_manager.sv
module pfq_manager #(
    parameter int AW        = 32,
    parameter int TW        = 32,
    parameter int DW        = 8,
    parameter int DEPTH     = 100,
    parameter int NC        = 4,
    parameter int BLK_BYTES = 64,
    parameter int CW        = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_chk_on_push,
    input  logic                   cfg_serial_squash,
    input  logic                   cfg_data_only,
    input  logic                   ntf_valid,
    input  logic [AW-1:0]          ntf_addr,
    input  logic [TW-1:0]          ntf_time,
    input  logic                   ntf_uncached,
    input  logic                   ntf_ifetch,
    input  logic [NC-1:0]          cand_valid,
    input  logic [NC-1:0][AW-1:0]  cand_addr,
    input  logic [NC-1:0][DW-1:0]  cand_delay,
    input  logic [NC-1:0]          cand_in_cache,
    input  logic [NC-1:0]          cand_in_mshr,
    input  logic                   pop_req,
    input  logic                   pop_head_in_cache,
    output logic                   head_valid,
    output logic [AW-1:0]          head_addr,
    output logic [TW-1:0]          head_ready,
    output logic                   rsp_valid,
    output logic [TW-1:0]          rsp_time,
    output logic                   pop_valid,
    output logic [AW-1:0]          pop_addr,
    output logic [CW-1:0]          cnt_identified,
    output logic [CW-1:0]          cnt_issued,
    output logic [CW-1:0]          cnt_rm_miss,
    output logic [CW-1:0]          cnt_rm_full,
    output logic [CW-1:0]          cnt_squashed,
    output logic [CW-1:0]          cnt_dup
);
    import pfq_pkg::*;

    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int MAXQ = (DEPTH > NC) ? DEPTH : NC;
    localparam int IW   = $clog2(MAXQ + 1);
    localparam logic [AW-1:0] BLK_MASK = ~AW'(BLK_BYTES - 1);

    pfq_cfg_t                  cfg;
    logic                      ntf_act;
    logic [AW-1:0]             ntf_blk;
    logic [NC-1:0][AW-1:0]     cand_blk;
    logic [NC-1:0]             cand_pass;
    logic [CNTW-1:0]           occupancy;
    logic [PFQ_NUM_EV-1:0][IW-1:0] ev_inc;
    logic [PFQ_NUM_EV-1:0][CW-1:0] ev_cnt;

    assign cfg.chk_on_push   = cfg_chk_on_push;
    assign cfg.serial_squash = cfg_serial_squash;
    assign cfg.data_only     = cfg_data_only;

    assign ntf_act = ntf_valid && !ntf_uncached && !(ntf_ifetch && cfg.data_only);
    assign ntf_blk = ntf_addr & BLK_MASK;

    pfq_cand_filter #(
        .AW(AW), .NC(NC), .BLK_BYTES(BLK_BYTES)
    ) filt_i (
        .chk_on_push  (cfg.chk_on_push),
        .cand_valid   (cand_valid),
        .cand_addr    (cand_addr),
        .cand_in_cache(cand_in_cache),
        .cand_in_mshr (cand_in_mshr),
        .cand_blk     (cand_blk),
        .cand_pass    (cand_pass)
    );

    pfq_store #(
        .AW(AW), .TW(TW), .DW(DW), .DEPTH(DEPTH), .NC(NC),
        .CNTW(CNTW), .IW(IW)
    ) store_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .chk_on_push      (cfg.chk_on_push),
        .serial_squash    (cfg.serial_squash),
        .ntf_act          (ntf_act),
        .ntf_blk          (ntf_blk),
        .ntf_time         (ntf_time),
        .cand_pass        (cand_pass),
        .cand_blk         (cand_blk),
        .cand_delay       (cand_delay),
        .pop_req          (pop_req),
        .pop_head_in_cache(pop_head_in_cache),
        .head_valid       (head_valid),
        .head_addr        (head_addr),
        .head_ready       (head_ready),
        .rsp_valid        (rsp_valid),
        .rsp_time         (rsp_time),
        .pop_valid        (pop_valid),
        .pop_addr         (pop_addr),
        .occupancy        (occupancy),
        .inc_issued       (ev_inc[EV_ISSUED]),
        .inc_rm_miss      (ev_inc[EV_RM_MISS]),
        .inc_rm_full      (ev_inc[EV_RM_FULL]),
        .inc_squash       (ev_inc[EV_SQUASH]),
        .inc_dup          (ev_inc[EV_DUP])
    );

    assign ev_inc[EV_IDENT] = ntf_act ? IW'($countones(cand_valid)) : '0;

    for (genvar e = 0; e < PFQ_NUM_EV; e++) begin : g_ev
        pfq_event_ctr #(.CW(CW), .IW(IW)) ctr_i (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (ev_inc[e]),
            .count(ev_cnt[e])
        );
    end

    assign cnt_identified = ev_cnt[EV_IDENT];
    assign cnt_issued     = ev_cnt[EV_ISSUED];
    assign cnt_rm_miss    = ev_cnt[EV_RM_MISS];
    assign cnt_rm_full    = ev_cnt[EV_RM_FULL];
    assign cnt_squashed   = ev_cnt[EV_SQUASH];
    assign cnt_dup        = ev_cnt[EV_DUP];

    AST_IGNORED_NTF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_valid && (ntf_uncached || (ntf_ifetch && cfg_data_only)) && !pop_req)
        |=> ($stable(occupancy) && !rsp_valid && $stable(cnt_identified))); // R11

    AST_HEAD_MATCHES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!head_valid) |-> (head_ready == '1)); // R9

endmodule

// File: tb/pfq_manager_tb.sv
`timescale 1ns/1ps
module pfq_manager_tb_top;
    localparam int AW = 16, TW = 16, DW = 4, DEPTH = 4, NC = 3, BLK = 16, CW = 4;
    localparam int CMAX = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_chk_on_push = 1'b1, cfg_serial_squash = 1'b0, cfg_data_only = 1'b1;
    logic ntf_valid = 1'b0, ntf_uncached = 1'b0, ntf_ifetch = 1'b0;
    logic [AW-1:0] ntf_addr = '0;
    logic [TW-1:0] ntf_time = '0;
    logic [NC-1:0] cand_valid = '0, cand_in_cache = '0, cand_in_mshr = '0;
    logic [NC-1:0][AW-1:0] cand_addr = '0;
    logic [NC-1:0][DW-1:0] cand_delay = '0;
    logic pop_req = 1'b0, pop_head_in_cache = 1'b0;
    logic head_valid, rsp_valid, pop_valid;
    logic [AW-1:0] head_addr, pop_addr;
    logic [TW-1:0] head_ready, rsp_time;
    logic [CW-1:0] cnt_identified, cnt_issued, cnt_rm_miss, cnt_rm_full, cnt_squashed, cnt_dup;

    always #2 clk = ~clk;

    pfq_manager #(.AW(AW), .TW(TW), .DW(DW), .DEPTH(DEPTH), .NC(NC),
                  .BLK_BYTES(BLK), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_chk_on_push(cfg_chk_on_push), .cfg_serial_squash(cfg_serial_squash),
        .cfg_data_only(cfg_data_only),
        .ntf_valid(ntf_valid), .ntf_addr(ntf_addr), .ntf_time(ntf_time),
        .ntf_uncached(ntf_uncached), .ntf_ifetch(ntf_ifetch),
        .cand_valid(cand_valid), .cand_addr(cand_addr), .cand_delay(cand_delay),
        .cand_in_cache(cand_in_cache), .cand_in_mshr(cand_in_mshr),
        .pop_req(pop_req), .pop_head_in_cache(pop_head_in_cache),
        .head_valid(head_valid), .head_addr(head_addr), .head_ready(head_ready),
        .rsp_valid(rsp_valid), .rsp_time(rsp_time),
        .pop_valid(pop_valid), .pop_addr(pop_addr),
        .cnt_identified(cnt_identified), .cnt_issued(cnt_issued),
        .cnt_rm_miss(cnt_rm_miss), .cnt_rm_full(cnt_rm_full),
        .cnt_squashed(cnt_squashed), .cnt_dup(cnt_dup)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [AW-1:0] mq_a[$];
    logic [TW-1:0] mq_t[$];
    int e_ident = 0, e_issued = 0, e_miss = 0, e_full = 0, e_squash = 0, e_dup = 0;
    logic exp_rsp_v = 0, exp_pop_v = 0;
    logic [TW-1:0] exp_rsp_t = '0;
    logic [AW-1:0] exp_pop_a = '0;

    function automatic int sat(int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    function automatic logic [AW-1:0] blk_of(logic [AW-1:0] a);
        return a & ~AW'(BLK - 1);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference model: applies the requirements to the inputs now driven
    task automatic model_step();
        logic act;
        logic [AW-1:0] b;
        int hit;
        logic dup;
        exp_pop_v = 0;
        exp_rsp_v = 0;
        if (pop_req && mq_a.size() > 0) begin               // R10, R13
            if (!(!cfg_chk_on_push && pop_head_in_cache)) begin
                exp_pop_v = 1; exp_pop_a = mq_a[0];
                e_issued = sat(e_issued + 1);
            end
            void'(mq_a.pop_front()); void'(mq_t.pop_front());
        end
        act = ntf_valid && !ntf_uncached && !(ntf_ifetch && cfg_data_only);
        if (act) begin
            b = blk_of(ntf_addr);
            hit = -1;
            for (int i = 0; i < mq_a.size(); i++) if (hit < 0 && mq_a[i] == b) hit = i;
            if (hit >= 0) begin
                mq_a.delete(hit); mq_t.delete(hit);
                e_miss = sat(e_miss + 1);
            end
            if (cfg_serial_squash) begin
                while (mq_a.size() > 0 && mq_t[mq_t.size()-1] >= ntf_time) begin
                    void'(mq_a.pop_back()); void'(mq_t.pop_back());
                    e_squash = sat(e_squash + 1);
                end
            end
            for (int c = 0; c < NC; c++) begin
                if (cand_valid[c]) begin
                    e_ident = sat(e_ident + 1);
                    b = blk_of(cand_addr[c]);
                    if (!(cfg_chk_on_push && cand_in_cache[c]) && !cand_in_mshr[c]) begin
                        dup = 0;
                        for (int i = 0; i < mq_a.size(); i++) if (mq_a[i] == b) dup = 1;
                        if (dup) e_dup = sat(e_dup + 1);
                        else begin
                            if (mq_a.size() == DEPTH) begin
                                void'(mq_a.pop_front()); void'(mq_t.pop_front());
                                e_full = sat(e_full + 1);
                            end
                            mq_a.push_back(b);
                            mq_t.push_back(ntf_time + TW'(cand_delay[c]));
                        end
                    end
                end
            end
            exp_rsp_v = 1;
            exp_rsp_t = (mq_a.size() > 0) ? mq_t[0] : '0;
        end
    endtask

    task automatic compare();
        chk("R8 rsp_valid", 32'(rsp_valid), 32'(exp_rsp_v));
        if (exp_rsp_v) chk("R8 rsp_time", 32'(rsp_time), 32'(exp_rsp_t));
        chk("R10 pop_valid", 32'(pop_valid), 32'(exp_pop_v));
        if (exp_pop_v) chk("R10 pop_addr", 32'(pop_addr), 32'(exp_pop_a));
        chk("R9 head_ready", 32'(head_ready), (mq_a.size() > 0) ? 32'(mq_t[0]) : 32'hFFFF);
        if (mq_a.size() > 0) chk("R9 head_addr", 32'(head_addr), 32'(mq_a[0]));
        chk("R12 cnt_identified", 32'(cnt_identified), 32'(e_ident));
        chk("R12 cnt_issued", 32'(cnt_issued), 32'(e_issued));
        chk("R3 cnt_rm_miss", 32'(cnt_rm_miss), 32'(e_miss));
        chk("R6 cnt_rm_full", 32'(cnt_rm_full), 32'(e_full));
        chk("R4 cnt_squashed", 32'(cnt_squashed), 32'(e_squash));
        chk("R5 cnt_dup", 32'(cnt_dup), 32'(e_dup));
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle_inputs();
        ntf_valid = 0; ntf_uncached = 0; ntf_ifetch = 0; ntf_addr = '0;
        cand_valid = '0; cand_in_cache = '0; cand_in_mshr = '0;
        pop_req = 0; pop_head_in_cache = 0;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 head_valid", 32'(head_valid), 32'd0);
        chk("R1 head_ready", 32'(head_ready), 32'hFFFF);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 pop_valid", 32'(pop_valid), 32'd0);
        chk("R1 counters", 32'({cnt_identified, cnt_issued, cnt_rm_miss,
                                 cnt_rm_full, cnt_squashed, cnt_dup}), 32'd0);

        // R7: ready time = notification time + delay
        idle_inputs();
        ntf_valid = 1; ntf_addr = 16'h0105; ntf_time = 16'd100;
        cand_valid = 3'b001; cand_addr[0] = 16'h0207; cand_delay[0] = 4'd5;
        step();
        chk("R7 appended ready time", 32'(head_ready), 32'd105);

        // R2: offset bits ignored when matching the demand block
        idle_inputs();
        ntf_valid = 1; ntf_addr = 16'h020C; ntf_time = 16'd101;
        step();
        chk("R2 aligned match removed entry", 32'(head_ready), 32'hFFFF);

        // R11: ignored notifications
        idle_inputs();
        ntf_valid = 1; ntf_addr = 16'h0010; ntf_time = 16'd110;
        cand_valid = 3'b001; cand_addr[0] = 16'h0300; cand_delay[0] = 4'd2;
        step();
        idle_inputs();
        ntf_valid = 1; ntf_ifetch = 1; ntf_addr = 16'h0301; ntf_time = 16'd111;
        cand_valid = 3'b010; cand_addr[1] = 16'h0400;
        step();
        chk("R11 ifetch ignored head", 32'(head_ready), 32'd112);
        chk("R11 ifetch ignored rsp", 32'(rsp_valid), 32'd0);
        idle_inputs();
        ntf_valid = 1; ntf_uncached = 1; ntf_addr = 16'h0302; ntf_time = 16'd112;
        step();
        chk("R11 uncached ignored head", 32'(head_ready), 32'd112);

        // R13: pop acts before the notification in the same cycle
        idle_inputs();
        pop_req = 1;
        ntf_valid = 1; ntf_addr = 16'h0500; ntf_time = 16'd120;
        cand_valid = 3'b001; cand_addr[0] = 16'h0300; cand_delay[0] = 4'd1;
        step();
        chk("R13 popped old entry", 32'(pop_addr), 32'h0300);
        chk("R13 re-appended after pop", 32'(head_ready), 32'd121);

        // constrained random phase
        for (int n = 0; n < 3000; n++) begin
            if (n % 200 == 0) begin
                cfg_chk_on_push   = 1'($urandom % 2);
                cfg_serial_squash = 1'($urandom % 2);
                cfg_data_only     = 1'($urandom % 2);
            end
            idle_inputs();
            ntf_time     = 16'(200 + n);
            ntf_valid    = ($urandom % 10) < 6;
            ntf_addr     = 16'((($urandom % 8) << 4) | ($urandom % 16));
            ntf_uncached = ($urandom % 10) == 0;
            ntf_ifetch   = ($urandom % 5) == 0;
            for (int c = 0; c < NC; c++) begin
                cand_valid[c]    = ($urandom % 10) < 7;
                cand_addr[c]     = 16'((($urandom % 8) << 4) | ($urandom % 16));
                cand_delay[c]    = 4'($urandom % 16);
                cand_in_cache[c] = ($urandom % 5) == 0;
                cand_in_mshr[c]  = ($urandom % 7) == 0;
            end
            pop_req           = ($urandom % 10) < 3;
            pop_head_in_cache = ($urandom % 10) < 3;
            step();
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule